// File: doc/BRIEF.md
# SPI Pause Gate

This block sits between the four serial pins of an SPI slave and the slave's shift logic, which runs on a fast system clock. It adds a pause input, `hold_n`. A transfer in progress can be frozen with it and then resumed. The serial sequence is not restarted.

All pin inputs are first brought into the system clock domain through synchronisers. From the synchronised SCK the block derives two strobes. `shift_en` marks a rising SCK edge, where the slave captures SI. `shift_out` marks a falling SCK edge, where the slave advances its output bit. Both strobes are suppressed while the block is paused. The block also keeps the bit position inside the current word and holds it frozen through a pause.

The pause state is decided only while SCK is low. A change of `hold_n` while SCK is high waits until SCK is next low. While paused, the slave's serial output is forced to high impedance. The slave's data and enable are passed through otherwise. Raising chip select ends the transfer and clears both the pause and the bit position.

Top module: `spi_pause_gate`

## Requirements
- R1: After reset, `shift_en` and `shift_out` are 0, `so_oe` is 0 and `bit_idx` is 0.
- R2: While selected (`cs_n` low) and not paused, each rising SCK edge gives exactly one single-cycle `shift_en` pulse. During that pulse `si_data` equals the SI level presented with the edge, and `bit_idx` still shows the position before the edge.
- R3: While selected and not paused, each falling SCK edge gives exactly one single-cycle `shift_out` pulse, and `bit_idx` does not change.
- R4: When `hold_n` is low while SCK is low and the block is selected, the block enters the pause. From then on, SCK edges produce neither `shift_en` nor `shift_out` pulses.
- R5: While paused, `so_oe` is 0 and `so_out` is 0, whatever the slave drives.
- R6: When `hold_n` is high while SCK is low, the pause ends. Following SCK rising edges produce `shift_en` again.
- R7: `bit_idx` advances by one after each `shift_en` pulse and wraps from WORD_BITS-1 to 0. It keeps its value through a pause, including while SCK toggles.
- R8: A change of `hold_n` while SCK is high takes no effect until SCK is low. A falling edge that arrives while entry is deferred still gives a `shift_out` pulse. While exit is deferred, output stays disabled and the next falling edge gives no pulse.
- R9: While `cs_n` is high, `hold_n` has no effect. A rising `cs_n` clears the pause and returns `bit_idx` to 0. Selecting while `hold_n` is low and SCK is low enters the pause at once.
- R10: While selected and not paused, `so_oe` equals `slv_so_en` and `so_out` equals `slv_so` when enabled. When deselected, `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin, asynchronous |
| si | input | 1 | Serial data in pin, asynchronous |
| hold_n | input | 1 | Pause request pin, active low, asynchronous |
| slv_so | input | 1 | Output bit from the slave's shift logic |
| slv_so_en | input | 1 | Output enable from the slave's shift logic |
| shift_en | output | 1 | One-cycle strobe: capture `si_data` (rising SCK) |
| shift_out | output | 1 | One-cycle strobe: advance output bit (falling SCK) |
| si_data | output | 1 | Synchronised SI, valid with `shift_en` |
| bit_idx | output | IDX_W | Bit position in the current word |
| so_out | output | 1 | Gated serial output data |
| so_oe | output | 1 | Serial output drive enable; 0 means high impedance |

## Verification
A pin change set up after clock edge E0 passes two synchroniser stages. A SCK edge then shows as a strobe in the cycle after edge E2, and `bit_idx` moves at E3. A pause entry or exit is registered at E3, while a deselect removes `so_oe` right after E2. The bench holds every pin level for six clocks and drives 1 ns after a rising edge. Its monitor samples on falling edges, so each expected strobe is compared in the single cycle it is valid. Any extra or missing strobe is caught by the scoreboard queue, and each state check waits until all pipeline stages have settled.

// File: rtl/spi_pause_gate.sv
module spi_pause_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS   = 8,
  localparam int IDX_W      = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             si,
  input  logic             hold_n,
  input  logic             slv_so,
  input  logic             slv_so_en,
  output logic             shift_en,
  output logic             shift_out,
  output logic             si_data,
  output logic [IDX_W-1:0] bit_idx,
  output logic             so_out,
  output logic             so_oe
);

  localparam logic [3:0] PIN_RST = 4'b1001;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_BITS - 1);

  logic [3:0] sync_q [SYNC_STAGES];
  logic       cs_s, sck_s, hold_s;
  logic       sck_d;
  logic       held;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= PIN_RST;
      else if (g == 0) sync_q[g] <= {hold_n, si, sck, cs_n};
      else sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
    end
  end

  assign cs_s    = sync_q[SYNC_STAGES-1][0];
  assign sck_s   = sync_q[SYNC_STAGES-1][1];
  assign si_data = sync_q[SYNC_STAGES-1][2];
  assign hold_s  = sync_q[SYNC_STAGES-1][3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      held  <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (cs_s) held <= 1'b0;
      else if (!sck_s) held <= !hold_s;
    end
  end

  wire active = !cs_s && !held;
  assign shift_en  = active && sck_s && !sck_d;
  assign shift_out = active && !sck_s && sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_idx <= '0;
    else if (cs_s) bit_idx <= '0;
    else if (shift_en) bit_idx <= (bit_idx == IDX_LAST) ? '0 : bit_idx + 1'b1;
  end

  assign so_oe  = active && slv_so_en;
  assign so_out = so_oe && slv_so;

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> bit_idx == '0 && !so_oe);

  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en);

  p_fall_keeps_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_out |=> $stable(bit_idx));

  p_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_s && !sck_s && !hold_s) |-> !so_oe && !so_out);

  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_s && !sck_s && hold_s) && $rose(sck_s) |-> shift_en);

  p_idx_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(held) && held |-> $stable(bit_idx));

  p_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sck_s) && !$past(cs_s) |-> held == $past(held));

  p_deselect_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> !held && bit_idx == '0);

endmodule

// File: tb/test_spi_pause_gate.sv
module test_spi_pause_gate;
  localparam int WB = 8;
  localparam int HOLDC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic slv_so = 1'b0, slv_so_en = 1'b0;
  logic shift_en, shift_out, si_data, so_out, so_oe;
  logic [2:0] bit_idx;

  always #2.5 clk = ~clk;

  spi_pause_gate #(.SYNC_STAGES(2), .WORD_BITS(WB)) i_spi_pause_gate (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .slv_so(slv_so), .slv_so_en(slv_so_en), .shift_en(shift_en), .shift_out(shift_out),
    .si_data(si_data), .bit_idx(bit_idx), .so_out(so_out), .so_oe(so_oe));

  typedef struct { bit rise; bit sbit; int idx; string req; } ev_t;
  ev_t q[$];
  int compared = 0, mismatched = 0;
  int exp_idx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rise(input bit b, input bit expect_pulse, input string req);
    sck = 1'b1; si = b;
    if (expect_pulse) begin
      q.push_back('{1'b1, b, exp_idx, req});
      exp_idx = (exp_idx + 1) % WB;
    end
    step(HOLDC);
  endtask

  task automatic fall(input bit expect_pulse, input string req);
    sck = 1'b0;
    if (expect_pulse) q.push_back('{1'b0, 1'b0, exp_idx, req});
    step(HOLDC);
  endtask

  task automatic drained(input string req);
    chk(q.size() == 0, req, q.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && (shift_en || shift_out)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4 unexpected strobe", int'(shift_en), 0);
      end else begin
        ev_t e;
        e = q.pop_front();
        chk(shift_en == e.rise && shift_out == !e.rise, e.req, int'(shift_en), int'(e.rise));
        if (e.rise) chk(si_data == e.sbit, e.req, int'(si_data), int'(e.sbit));
        chk(int'(bit_idx) == e.idx, {e.req, " R7 idx"}, int'(bit_idx), e.idx);
      end
    end
  end

  initial begin
    step(3);
    chk(!shift_en && !shift_out, "R1 strobes", int'(shift_en), 0);
    chk(!so_oe && bit_idx == 0, "R1 oe/idx", int'(so_oe), 0);
    rst_n = 1'b1;
    step(4);
    chk(!so_oe && bit_idx == 0, "R1 after release", int'(bit_idx), 0);

    slv_so_en = 1'b1; slv_so = 1'b1;
    hold_n = 1'b0; step(HOLDC); hold_n = 1'b1; step(HOLDC);
    chk(!so_oe, "R10 deselected oe", int'(so_oe), 0);

    cs_n = 1'b0; step(HOLDC);
    chk(so_oe && so_out, "R10 pass one", int'(so_out), 1);
    slv_so = 1'b0; step(1);
    chk(so_oe && !so_out, "R10 pass zero", int'(so_out), 0);
    slv_so = 1'b1;

    rise(1, 1, "R2 bit a"); fall(1, "R3 fall a");
    rise(0, 1, "R2 bit b"); fall(1, "R3 fall b");
    rise(1, 1, "R2 bit c"); fall(1, "R3 fall c");
    drained("R2 all strobes seen");
    chk(int'(bit_idx) == 3, "R7 idx after three", int'(bit_idx), 3);

    hold_n = 1'b0; step(HOLDC);
    chk(!so_oe && !so_out, "R5 paused oe", int'(so_oe), 0);
    rise(0, 0, "R4 held"); fall(0, "R4 held");
    rise(1, 0, "R4 held"); fall(0, "R4 held");
    drained("R4 no strobes while paused");
    chk(int'(bit_idx) == 3, "R7 idx frozen", int'(bit_idx), 3);
    hold_n = 1'b1; step(HOLDC);
    chk(so_oe, "R6 oe back", int'(so_oe), 1);
    rise(0, 1, "R6 resume bit"); fall(1, "R6 resume fall");
    drained("R6 resumed");

    rise(1, 1, "R2 bit e");
    hold_n = 1'b0; step(HOLDC);
    chk(so_oe, "R8 entry deferred", int'(so_oe), 1);
    fall(1, "R8 fall during deferred entry");
    chk(!so_oe, "R8 entry after low", int'(so_oe), 0);
    rise(0, 0, "R8 held");
    hold_n = 1'b1; step(HOLDC);
    chk(!so_oe, "R8 exit deferred", int'(so_oe), 0);
    fall(0, "R8 no fall strobe");
    chk(so_oe, "R8 exit after low", int'(so_oe), 1);
    drained("R8 deferral");
    chk(int'(bit_idx) == 5, "R7 idx kept", int'(bit_idx), 5);

    rise(1, 1, "R7 bit f"); fall(1, "R7 f");
    rise(0, 1, "R7 bit g"); fall(1, "R7 g");
    rise(1, 1, "R7 bit h"); fall(1, "R7 h");
    drained("R7 word done");
    chk(int'(bit_idx) == 0, "R7 wrap", int'(bit_idx), 0);
    rise(1, 1, "R7 after wrap"); fall(1, "R7 after wrap");
    chk(int'(bit_idx) == 1, "R7 next word", int'(bit_idx), 1);

    hold_n = 1'b0; step(HOLDC);
    cs_n = 1'b1; exp_idx = 0; step(HOLDC);
    chk(!so_oe && bit_idx == 0, "R9 deselect clears", int'(bit_idx), 0);
    cs_n = 1'b0; step(HOLDC);
    chk(!so_oe, "R9 select while hold low", int'(so_oe), 0);
    rise(1, 0, "R9 held at select"); fall(0, "R9 held");
    hold_n = 1'b1; step(HOLDC);
    chk(so_oe, "R9 released", int'(so_oe), 1);
    rise(1, 1, "R9 first bit idx0"); fall(1, "R9 fall");
    drained("R9 sequence");
    cs_n = 1'b1; step(HOLDC);
    chk(!so_oe, "R10 oe off on deselect", int'(so_oe), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule